// File: doc/BRIEF.md
# Slot-16 Signalling Multiframe Inserter

This block builds the octet that a 32-slot frame formatter places in time slot 16 of every frame. Each of the 30 voice channels owns a 4-bit signalling state. Software or a call-control engine loads these states through a simple write port. Over a 16-frame multiframe the block sends two channel states per frame. The multiframe alignment word goes in the frame numbered 0. Every channel is therefore refreshed once per multiframe, which is once every 2 ms at the nominal frame rate.

A frame-start strobe, one clock wide, marks each new frame. The edge that carries the strobe forms the next octet and holds it until the next strobe. A small state machine tracks the multiframe position. It has three states. `ST_WAIT` is the state after reset, before any strobe has arrived. `ST_ALIGN` is active while frame 0 is being output. `ST_CHAN` is active during frames 1 to 15. The transitions are:
- `go_first`: `ST_WAIT` to `ST_ALIGN`, on the first strobe.
- `go_chan`: `ST_ALIGN` to `ST_CHAN`, on the next strobe.
- `go_step`: `ST_CHAN` to `ST_CHAN`, on a strobe while the frame is below 15.
- `go_wrap`: `ST_CHAN` to `ST_ALIGN`, on a strobe in frame 15.

A write to a channel never changes the octet already on the output. It appears the next time that channel's frame is formed.

Top module: `sig_mf_inserter`

## Requirements
- R1: After reset, `mf_run` is 0, `mf_frame` is 0 and `ts16_octet` is 8'hFF. Every channel state resets to 4'b1101.
- R2: The first `frame_start` after reset starts the multiframe at frame 0 and sets `mf_run` to 1. `mf_run` then stays at 1.
- R3: Each later `frame_start` advances `mf_frame` by one, and frame 15 wraps to frame 0.
- R4: The frame-0 octet has bits [7:4] = 0000, bit 3 = 1, bit 2 = the value of `rmt_alarm` sampled with the strobe, and bits [1:0] = 11.
- R5: The octet of frame n, for n from 1 to 15, has bits [7:4] = the state of channel n and bits [3:0] = the state of channel n+15.
- R6: A write with `wr_en` high and `wr_chan` from 1 to 30 stores `wr_nibble` for that channel. The new value appears the next time that channel's frame is formed. A write in the same cycle as the strobe that forms that channel's frame is not seen in that octet.
- R7: A write with `wr_chan` equal to 0 or 31 changes no channel state.
- R8: `ts16_octet` and `mf_frame` change only on an edge where `frame_start` is 1. Writes between strobes do not disturb them.
- R9: `rmt_alarm` has no effect on the octets of frames 1 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that marks a new frame |
| rmt_alarm | input | 1 | Remote multiframe alarm bit for frame 0 |
| wr_en | input | 1 | Channel state write enable |
| wr_chan | input | 5 | Channel number for the write (1 to 30) |
| wr_nibble | input | 4 | Signalling state to store |
| ts16_octet | output | 8 | Octet for time slot 16 of the current frame |
| mf_frame | output | 4 | Current frame number in the multiframe |
| mf_run | output | 1 | High once the multiframe has started |

## Verification
The hardest case to reach is a write that lands in the same cycle as the strobe that forms that channel's own frame. Only that collision shows whether the octet takes the old or the new state. Random writes rarely hit it, so directed steps place a write to channel 5 and to channel 20 exactly on the strobe of frame 5. The next multiframe then confirms that the new value arrives. Random stimulus with a fixed seed covers the rest: strobes at uneven spacing, writes to the invalid channel numbers 0 and 31, and an alarm input that toggles during frames 1 to 15.

// File: rtl/sig_mf_pkg.sv
package sig_mf_pkg;
    localparam int NIB_W = 4;
    localparam int OCT_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_CHAN  = 2'd2
    } mf_state_t;

    localparam logic [OCT_W-1:0] IDLE_OCTET = 8'hFF;
    localparam logic [NIB_W-1:0] RESET_NIB  = 4'b1101;
endpackage

// File: rtl/sig_nibble_store.sv
module sig_nibble_store
    import sig_mf_pkg::*;
#(
    parameter int CHANS = 30,
    localparam int CW = $clog2(CHANS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CW-1:0]                wr_chan,
    input  logic [NIB_W-1:0]             wr_nib,
    output logic [CHANS-1:0][NIB_W-1:0]  nib_all
);
    logic [CHANS-1:0][NIB_W-1:0] nib_q;

    for (genvar g = 0; g < CHANS; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q[g] <= RESET_NIB;
            end else if (wr_en && (wr_chan == CW'(g + 1))) begin
                nib_q[g] <= wr_nib;
            end
        end
    end

    assign nib_all = nib_q;

    logic bad_chan;
    assign bad_chan = (wr_chan == '0) || (wr_chan > CW'(CHANS));

    // R7: an out-of-range channel number leaves every state untouched
    assert_bad_chan_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bad_chan) |=> $stable(nib_q));

    // R6: a valid write is visible in the store one edge later
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bad_chan) |=> (nib_q[$past(wr_chan) - CW'(1)] == $past(wr_nib)));
endmodule

// File: rtl/sig_mf_fsm.sv
module sig_mf_fsm
    import sig_mf_pkg::*;
#(
    parameter int FRAMES = 16,
    localparam int FW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [FW-1:0] frame_q,
    output logic [FW-1:0] frame_nxt,
    output logic          run
);
    localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

    mf_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (frame_start) state_d = ST_ALIGN;            // go_first
            ST_ALIGN: if (frame_start) state_d = ST_CHAN;             // go_chan
            ST_CHAN:  if (frame_start)
                          state_d = (frame_q == LAST) ? ST_ALIGN      // go_wrap
                                                      : ST_CHAN;      // go_step
            default:  state_d = ST_WAIT;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            frame_q <= '0;
        end else if (frame_start) begin
            state_q <= state_d;
            frame_q <= frame_nxt;
        end
    end

    // output process
    always_comb begin
        run = (state_q != ST_WAIT);
        unique case (state_q)
            ST_WAIT:  frame_nxt = '0;
            ST_ALIGN: frame_nxt = FW'(1);
            ST_CHAN:  frame_nxt = (frame_q == LAST) ? '0 : frame_q + FW'(1);
            default:  frame_nxt = '0;
        endcase
    end

    // R3: the frame number advances by one per strobe
    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_start && frame_q != LAST) |=> (frame_q == $past(frame_q) + FW'(1)));

    // R3: frame 15 wraps to frame 0
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_start && frame_q == LAST) |=> (frame_q == '0));

    // R2: the alignment state always coincides with frame 0
    assert_align_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN) |-> (frame_q == '0));

    // R2: once started, the multiframe keeps running
    assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);
endmodule

// File: rtl/sig_octet_mux.sv
module sig_octet_mux
    import sig_mf_pkg::*;
#(
    parameter int FRAMES = 16,
    localparam int FW    = $clog2(FRAMES),
    localparam int CHANS = 2 * (FRAMES - 1),
    localparam int HALF  = FRAMES - 1,
    localparam int IW    = $clog2(CHANS)
) (
    input  logic [CHANS-1:0][NIB_W-1:0] nib_all,
    input  logic [FW-1:0]               frame_sel,
    input  logic                        alarm,
    output logic [OCT_W-1:0]            octet
);
    logic [IW-1:0] hi_idx, lo_idx;

    always_comb begin
        hi_idx = IW'(frame_sel) - IW'(1);
        lo_idx = IW'(frame_sel) + IW'(HALF - 1);
        if (frame_sel == '0) begin
            octet = {{NIB_W{1'b0}}, 1'b1, alarm, 2'b11};
        end else begin
            octet = {nib_all[hi_idx], nib_all[lo_idx]};
        end
    end
endmodule

// File: rtl/sig_mf_inserter.sv
module sig_mf_inserter
    import sig_mf_pkg::*;
#(
    parameter int FRAMES = 16,
    localparam int FW    = $clog2(FRAMES),
    localparam int CHANS = 2 * (FRAMES - 1),
    localparam int CW    = $clog2(CHANS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             rmt_alarm,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_chan,
    input  logic [NIB_W-1:0] wr_nibble,
    output logic [OCT_W-1:0] ts16_octet,
    output logic [FW-1:0]    mf_frame,
    output logic             mf_run
);
    logic [CHANS-1:0][NIB_W-1:0] nib_all;
    logic [FW-1:0]               frame_nxt;
    logic [OCT_W-1:0]            octet_d;
    logic [OCT_W-1:0]            octet_q;

    sig_nibble_store #(.CHANS(CHANS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_nib  (wr_nibble),
        .nib_all (nib_all)
    );

    sig_mf_fsm #(.FRAMES(FRAMES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_q     (mf_frame),
        .frame_nxt   (frame_nxt),
        .run         (mf_run)
    );

    sig_octet_mux #(.FRAMES(FRAMES)) u_mux (
        .nib_all   (nib_all),
        .frame_sel (frame_nxt),
        .alarm     (rmt_alarm),
        .octet     (octet_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            octet_q <= IDLE_OCTET;
        end else if (frame_start) begin
            octet_q <= octet_d;
        end
    end

    assign ts16_octet = octet_q;

    // R1: the idle octet is held until the multiframe starts
    assert_idle_octet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_run |-> (ts16_octet == IDLE_OCTET));

    // R8: outputs hold between strobes
    assert_hold_between_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(ts16_octet) && $stable(mf_frame)));

    // R4: fixed bits of the alignment octet
    assert_align_layout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_run && mf_frame == '0) |-> (ts16_octet[7:3] == 5'b00001 && ts16_octet[1:0] == 2'b11));
endmodule

// File: tb/test_sig_mf_inserter.sv
module test_sig_mf_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       rmt_alarm = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_chan = '0;
    logic [3:0] wr_nibble = '0;
    logic [7:0] ts16_octet;
    logic [3:0] mf_frame;
    logic       mf_run;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] mdl [0:31];
    int         exp_frame;
    bit         exp_run;
    logic [7:0] exp_oct;

    always #2 clk = ~clk;

    sig_mf_inserter i_sig_mf_inserter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rmt_alarm(rmt_alarm),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_nibble(wr_nibble),
        .ts16_octet(ts16_octet), .mf_frame(mf_frame), .mf_run(mf_run)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] f_octet(input int fr, input bit al);
        if (fr == 0) return {4'b0000, 1'b1, al, 2'b11};
        return {mdl[fr], mdl[fr + 15]};
    endfunction

    task automatic cyc(input bit fs, input bit we, input logic [4:0] ch,
                       input logic [3:0] nb, input bit al, input string tg);
        @(negedge clk);
        frame_start = fs; wr_en = we; wr_chan = ch; wr_nibble = nb; rmt_alarm = al;
        @(posedge clk);
        if (fs) begin
            if (!exp_run) begin exp_run = 1'b1; exp_frame = 0; end
            else exp_frame = (exp_frame + 1) % 16;
            exp_oct = f_octet(exp_frame, al);
        end
        if (we && ch >= 1 && ch <= 30) mdl[ch] = nb;
        #1;
        if (fs) begin
            chk(ts16_octet == exp_oct, {tg, " octet"}, ts16_octet, exp_oct);
            chk(mf_frame == 4'(exp_frame), "R3 frame", mf_frame, exp_frame);
            chk(mf_run == 1'b1, "R2 run", mf_run, 1);
        end else begin
            chk(ts16_octet == exp_oct, "R8 octet hold", ts16_octet, exp_oct);
            chk(mf_frame == 4'(exp_frame), "R8 frame hold", mf_frame, exp_frame);
        end
    endtask

    task automatic one_mf(input bit al0, input string tg);
        for (int f = 0; f < 16; f++) begin
            int nf = (exp_frame + 1) % 16;
            cyc(1'b1, 1'b0, 5'd0, 4'd0, (nf == 0) ? al0 : 1'($urandom_range(1)),
                (nf == 0) ? "R4" : tg);
        end
    endtask

    initial begin
        void'($urandom(32'd7391));
        for (int i = 0; i < 32; i++) mdl[i] = 4'b1101;
        exp_frame = 0; exp_run = 1'b0; exp_oct = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(ts16_octet == 8'hFF, "R1 idle octet", ts16_octet, 8'hFF);
        chk(mf_run == 1'b0, "R1 run", mf_run, 0);
        chk(mf_frame == 4'd0, "R1 frame", mf_frame, 0);

        // R1/R2/R5: first multiframe shows reset states
        cyc(1'b1, 1'b0, 5'd0, 4'd0, 1'b0, "R2 first");
        for (int f = 1; f < 16; f++) cyc(1'b1, 1'b0, 5'd0, 4'd0, 1'b1, "R1 reset nibble R9");

        // R8: load all channels without strobes
        for (int c = 1; c <= 30; c++) cyc(1'b0, 1'b1, 5'(c), 4'(c ^ 5), 1'b0, "R8");
        one_mf(1'b1, "R5 R9");
        one_mf(1'b0, "R5");

        // R6: same-cycle write on frame 5 strobe (channel 5 and channel 20)
        while (exp_frame != 4) cyc(1'b1, 1'b0, 5'd0, 4'd0, 1'b0, "R5");
        cyc(1'b1, 1'b1, 5'd5, 4'hA, 1'b0, "R6 same-cycle");
        while (exp_frame != 4) cyc(1'b1, 1'b0, 5'd0, 4'd0, 1'b0, "R5");
        cyc(1'b1, 1'b1, 5'd20, 4'h3, 1'b0, "R6 new value seen");
        while (exp_frame != 4) cyc(1'b1, 1'b0, 5'd0, 4'd0, 1'b0, "R5");
        cyc(1'b1, 1'b0, 5'd0, 4'd0, 1'b0, "R6 second value seen");

        // R7: invalid channel numbers
        cyc(1'b0, 1'b1, 5'd0, 4'h0, 1'b0, "R7");
        cyc(1'b0, 1'b1, 5'd31, 4'h0, 1'b0, "R7");
        cyc(1'b1, 1'b1, 5'd31, 4'h6, 1'b0, "R7");
        one_mf(1'b1, "R7 unchanged");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit fs = ($urandom_range(3) == 0);
            string tg = (exp_run && ((exp_frame + 1) % 16 == 0)) ? "R4 rnd" : "R5 R6 R9 rnd";
            cyc(fs, 1'($urandom_range(1)), 5'($urandom_range(31)),
                4'($urandom_range(15)), 1'($urandom_range(1)), tg);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule